// File: doc/BRIEF.md
# Grouped Flag Bit Register

This block holds sixteen single-bit software flags for a small 4-bit controller. Two one-byte instructions work on it. One sets a chosen flag and the other clears it. The upper nibble of the instruction byte picks the operation, and the lower nibble is the flag index. When the execute strobe is high and the opcode is one of the two, the addressed flag changes at the next clock edge. No other flag changes.

The flags are split into four nibble groups: flags 0–3, 4–7, 8–11 and 12–15. A clear does more than change one bit. In the same cycle it reports a zero-status value for the whole group that holds the addressed flag, taken as the group will stand after the clear. It also raises a write enable, so the controller's zero flag can capture that value at the same edge. A set leaves the zero flag alone. Other opcodes, and cycles without the strobe, do nothing.

Top module: `flag_bit_reg`

## Requirements
- R1: While rst_n is low at a rising clock edge, every flag is cleared to 0, whatever the other inputs are.
- R2: With exec_i high and opcode_i = 0101_bbbb (binary), flag b reads 1 on flags_o after the next rising edge.
- R3: With exec_i high and opcode_i = 0001_bbbb (binary), flag b reads 0 on flags_o after the next rising edge.
- R4: During an executed clear, zf_we_o is 1 in the same cycle. zf_val_o is 1 exactly when all four flags of group b[3:2] (flags 4*g to 4*g+3) are 0 once flag b has been cleared.
- R5: During an executed set, zf_we_o stays 0.
- R6: With exec_i low, or with an upper opcode nibble other than 0101 and 0001, flags_o keeps its value and zf_we_o is 0.
- R7: An executed set or clear changes no flag other than flag b.
- R8: Set and clear instructions may run on consecutive cycles. Each one acts on the flag state left by the one before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| exec_i | input | 1 | Execute strobe for the instruction on opcode_i |
| opcode_i | input | 8 | Instruction byte: upper nibble is the operation, lower nibble is the flag index |
| flags_o | output | 16 | Current flag values, bit n is flag n |
| zf_val_o | output | 1 | Zero-status value for the addressed group after the clear |
| zf_we_o | output | 1 | Zero-flag write enable, high during an executed clear |

## Verification
The bound checker covers the rules that hold on every cycle. A set or clear lands on the addressed bit (R2, R3). At most that one bit changes (R7). Idle or foreign cycles leave flags_o alone (R6). A set never raises zf_we_o (R5). The zero value reported during a clear matches the group as it stands after the edge (R4). Reset clearing (R1) can only be shown by the bench's scenarios. So can group-boundary behaviour, where clearing the last live bit of a group flips zf_val_o, and so can long back-to-back runs checked against an arithmetic model (R8).

// File: rtl/fbr_pkg.sv
// Package: shared operation codes and types for the grouped flag register.
// Assumes an instruction byte whose upper nibble selects the operation.
package fbr_pkg;

    localparam logic [3:0] OPC_SET_NIB = 4'b0101;
    localparam logic [3:0] OPC_CLR_NIB = 4'b0001;

    typedef enum logic [1:0] {
        FOP_NONE = 2'd0,
        FOP_SET  = 2'd1,
        FOP_CLR  = 2'd2
    } fop_e;

endpackage

// File: rtl/fbr_decode.sv
// Module: fbr_decode
// Turns the execute strobe and the instruction byte into an operation and a
// flag index. Assumes the opcode is the 4-bit operation nibble followed by
// an IDX_W-bit flag index.
module fbr_decode
    import fbr_pkg::*;
#(
    parameter int unsigned IDX_W = 4
) (
    input  logic              exec_i,
    input  logic [IDX_W+3:0]  opcode_i,
    output fop_e              op_o,
    output logic [IDX_W-1:0]  idx_o
);

    logic [3:0] op_nib;

    assign op_nib = opcode_i[IDX_W+3:IDX_W];
    assign idx_o  = opcode_i[IDX_W-1:0];

    // Purpose: classify the instruction; anything unknown or not executed is a no-op.
    always_comb begin
        op_o = FOP_NONE;
        if (exec_i) begin
            if (op_nib == OPC_SET_NIB) begin
                op_o = FOP_SET;
            end else if (op_nib == OPC_CLR_NIB) begin
                op_o = FOP_CLR;
            end
        end
    end

endmodule

// File: rtl/fbr_group.sv
// Module: fbr_group
// Holds one nibble group of flags. It applies a set or clear to the selected
// bit when grp_hit_i is high, and it reports whether the group would be all
// zero once the selected bit is cleared. Assumes GROUP_W is a power of two.
module fbr_group
    import fbr_pkg::*;
#(
    parameter int unsigned GROUP_W = 4,
    localparam int unsigned BSEL_W = (GROUP_W > 1) ? $clog2(GROUP_W) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               grp_hit_i,
    input  fop_e               op_i,
    input  logic [BSEL_W-1:0]  bit_sel_i,
    output logic [GROUP_W-1:0] bits_o,
    output logic               zero_after_clr_o
);

    logic [GROUP_W-1:0] bit_mask;
    logic [GROUP_W-1:0] bits_nxt;

    // Purpose: build a one-hot mask for the selected bit inside the group.
    always_comb begin
        for (int i = 0; i < GROUP_W; i++) begin
            bit_mask[i] = (bit_sel_i == BSEL_W'(i));
        end
    end

    // Purpose: work out the group's next value for a set, a clear, or a hold.
    always_comb begin
        bits_nxt = bits_o;
        if (grp_hit_i) begin
            case (op_i)
                FOP_SET: bits_nxt = bits_o | bit_mask;
                FOP_CLR: bits_nxt = bits_o & ~bit_mask;
                default: bits_nxt = bits_o;
            endcase
        end
    end

    // Purpose: group storage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_o <= '0;
        end else begin
            bits_o <= bits_nxt;
        end
    end

    // Purpose: zero status of the group after the addressed bit is cleared.
    assign zero_after_clr_o = ((bits_o & ~bit_mask) == '0);

endmodule

// File: rtl/fbr_zsel.sv
// Module: fbr_zsel
// Picks the zero status of the addressed group and raises the zero-flag
// write enable for clear operations only. Assumes one zero bit per group.
module fbr_zsel
    import fbr_pkg::*;
#(
    parameter int unsigned NUM_GROUPS = 4,
    localparam int unsigned GSEL_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
    input  fop_e                  op_i,
    input  logic [GSEL_W-1:0]     grp_sel_i,
    input  logic [NUM_GROUPS-1:0] grp_zero_i,
    output logic                  zf_val_o,
    output logic                  zf_we_o
);

    // Purpose: select the zero status of the addressed group.
    always_comb begin
        zf_val_o = 1'b0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (grp_sel_i == GSEL_W'(g)) begin
                zf_val_o = grp_zero_i[g];
            end
        end
    end

    // Purpose: only a clear writes the zero flag.
    assign zf_we_o = (op_i == FOP_CLR);

endmodule

// File: rtl/flag_bit_reg.sv
// Module: flag_bit_reg
// Top level of the grouped flag register: decode, one storage slice per
// nibble group, and zero-status selection. Assumes NUM_GROUPS and GROUP_W are
// powers of two, so the flag index splits into a group field and a bit field.
module flag_bit_reg
    import fbr_pkg::*;
#(
    parameter int unsigned NUM_GROUPS = 4,
    parameter int unsigned GROUP_W    = 4,
    localparam int unsigned NUM_FLAGS = NUM_GROUPS * GROUP_W,
    localparam int unsigned IDX_W     = $clog2(NUM_FLAGS),
    localparam int unsigned BSEL_W    = (GROUP_W > 1) ? $clog2(GROUP_W) : 1,
    localparam int unsigned GSEL_W    = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 exec_i,
    input  logic [IDX_W+3:0]     opcode_i,
    output logic [NUM_FLAGS-1:0] flags_o,
    output logic                 zf_val_o,
    output logic                 zf_we_o
);

    fop_e                  op;
    logic [IDX_W-1:0]      idx;
    logic [GSEL_W-1:0]     grp_sel;
    logic [BSEL_W-1:0]     bit_sel;
    logic [NUM_GROUPS-1:0] grp_zero;

    assign bit_sel = idx[BSEL_W-1:0];
    assign grp_sel = idx[IDX_W-1:BSEL_W];

    fbr_decode #(.IDX_W(IDX_W)) u_dec (
        .exec_i   (exec_i),
        .opcode_i (opcode_i),
        .op_o     (op),
        .idx_o    (idx)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic grp_hit;
        assign grp_hit = (grp_sel == GSEL_W'(g));
        fbr_group #(.GROUP_W(GROUP_W)) u_grp (
            .clk              (clk),
            .rst_n            (rst_n),
            .grp_hit_i        (grp_hit),
            .op_i             (op),
            .bit_sel_i        (bit_sel),
            .bits_o           (flags_o[g*GROUP_W +: GROUP_W]),
            .zero_after_clr_o (grp_zero[g])
        );
    end

    fbr_zsel #(.NUM_GROUPS(NUM_GROUPS)) u_zsel (
        .op_i       (op),
        .grp_sel_i  (grp_sel),
        .grp_zero_i (grp_zero),
        .zf_val_o   (zf_val_o),
        .zf_we_o    (zf_we_o)
    );

endmodule

// File: rtl/fbr_checker.sv
// Module: fbr_checker
// Cycle-by-cycle properties of flag_bit_reg, attached with bind.
// Assumes the opcode encodings from fbr_pkg.
module fbr_checker
    import fbr_pkg::*;
#(
    parameter int unsigned NUM_GROUPS = 4,
    parameter int unsigned GROUP_W    = 4,
    localparam int unsigned NUM_FLAGS = NUM_GROUPS * GROUP_W,
    localparam int unsigned IDX_W     = $clog2(NUM_FLAGS),
    localparam int unsigned BSEL_W    = (GROUP_W > 1) ? $clog2(GROUP_W) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 exec_i,
    input logic [IDX_W+3:0]     opcode_i,
    input logic [NUM_FLAGS-1:0] flags_o,
    input logic                 zf_val_o,
    input logic                 zf_we_o
);

    logic is_set;
    logic is_clr;
    logic [NUM_FLAGS-1:0] grp_mask;

    assign is_set   = exec_i && (opcode_i[IDX_W+3:IDX_W] == OPC_SET_NIB);
    assign is_clr   = exec_i && (opcode_i[IDX_W+3:IDX_W] == OPC_CLR_NIB);
    assign grp_mask = NUM_FLAGS'({GROUP_W{1'b1}});

    a_r2_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        is_set |=> flags_o[$past(opcode_i[IDX_W-1:0])] == 1'b1);

    a_r3_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
        is_clr |=> flags_o[$past(opcode_i[IDX_W-1:0])] == 1'b0);

    a_r4_zero_matches_group: assert property (@(posedge clk) disable iff (!rst_n)
        is_clr |=> $past(zf_val_o) ==
            (((flags_o >> ($past(opcode_i[IDX_W-1:BSEL_W]) * GROUP_W)) & grp_mask) == '0));

    a_r5_set_no_zf: assert property (@(posedge clk) disable iff (!rst_n)
        is_set |-> !zf_we_o);

    a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(is_set || is_clr) |=> $stable(flags_o));

    a_r6_idle_no_zf: assert property (@(posedge clk) disable iff (!rst_n)
        !is_clr |-> !zf_we_o);

    a_r7_one_bit_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (is_set || is_clr) |=> $countones(flags_o ^ $past(flags_o)) <= 1);

endmodule

bind flag_bit_reg fbr_checker #(.NUM_GROUPS(NUM_GROUPS), .GROUP_W(GROUP_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .exec_i   (exec_i),
    .opcode_i (opcode_i),
    .flags_o  (flags_o),
    .zf_val_o (zf_val_o),
    .zf_we_o  (zf_we_o)
);

// File: tb/sim_flag_bit_reg.sv
module sim_flag_bit_reg;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec_i = 1'b0;
    logic [7:0]  opcode_i = 8'h00;
    logic [15:0] flags_o;
    logic        zf_val_o;
    logic        zf_we_o;

    int checks = 0;
    int failures = 0;
    logic [15:0] model = 16'h0000;
    bit done = 1'b0;

    always #2 clk = ~clk;

    flag_bit_reg u0 (
        .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .opcode_i(opcode_i),
        .flags_o(flags_o), .zf_val_o(zf_val_o), .zf_we_o(zf_we_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One instruction cycle: drive at negedge, check zero outputs, then flags after the edge.
    task automatic step(input logic ex, input logic [7:0] op, input string req);
        logic        is_set;
        logic        is_clr;
        logic [15:0] after;
        logic [3:0]  grp_bits;
        @(negedge clk);
        exec_i   = ex;
        opcode_i = op;
        is_set = ex && (op[7:4] == 4'b0101);
        is_clr = ex && (op[7:4] == 4'b0001);
        after = model;
        if (is_set) after[op[3:0]] = 1'b1;
        if (is_clr) after[op[3:0]] = 1'b0;
        grp_bits = 4'((after >> (op[3:2] * 4)) & 16'h000F);
        #1;
        check({req, " zf_we"}, {31'd0, zf_we_o}, {31'd0, is_clr});
        if (is_clr) check({req, " R4 zf_val"}, {31'd0, zf_val_o}, {31'd0, grp_bits == 4'd0});
        @(posedge clk);
        #1;
        model = after;
        check({req, " flags"}, {16'd0, flags_o}, {16'd0, model});
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset wins over executed sets
        rst_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            exec_i = 1'b1;
            opcode_i = {4'b0101, 4'(i * 5)};
        end
        @(negedge clk);
        exec_i = 1'b0;
        check("R1 reset flags", {16'd0, flags_o}, 32'd0);
        rst_n = 1'b1;

        // R6: every opcode with exec low has no effect
        for (int op = 0; op < 256; op++) step(1'b0, 8'(op), "R6 exec low");

        // R2, R5, R7: set each flag in ascending order
        for (int b = 0; b < 16; b++) step(1'b1, {4'b0101, 4'(b)}, "R2 R5 R7 set");

        // R6: every foreign opcode executed on a full register
        for (int op = 0; op < 256; op++) begin
            if (op[7:4] != 4'b0101 && op[7:4] != 4'b0001)
                step(1'b1, 8'(op), "R6 foreign op");
        end

        // R3, R4, R7: clear each flag; the group's last clear reports zero
        for (int b = 0; b < 16; b++) step(1'b1, {4'b0001, 4'(b)}, "R3 R4 R7 clear");

        // R4: clear on already-empty group, and on a group with one other bit live
        step(1'b1, 8'h12, "R4 empty group");
        step(1'b1, 8'h59, "R2 set 9");
        step(1'b1, 8'h18, "R4 neighbour live");
        step(1'b1, 8'h19, "R4 last live");

        // R8: back-to-back random mix of sets, clears and others
        for (int n = 0; n < 4000; n++) begin
            logic [7:0] op;
            logic       ex;
            int unsigned r;
            r  = $urandom;
            ex = (r[3:0] != 4'd0);
            case (r[5:4])
                2'd0, 2'd1: op = {4'b0101, r[11:8]};
                2'd2:       op = {4'b0001, r[11:8]};
                default:    op = r[19:12];
            endcase
            step(ex, op, "R8 back-to-back");
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule